// File: doc/BRIEF.md
# Parity-Protected Branch Direction Table

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters, 4096 of them by default, and chooses an entry by XOR-ing the word-address bits of the fetch address with a global history register. A lookup presented in one cycle gives its answer in the next. A separate update port takes the real outcome of every branch that executes. That outcome trains the counter the branch maps to, and it is also shifted into the history.

Each stored counter carries an even-parity bit. When a word read back fails its parity check, the block quietly treats that counter as weakly not-taken. There is no error output, so a corrupted entry can only lead to a wrong guess.

A flush rewrites the whole table, one entry per clock, and raises `busy` until it is done. A flush starts by itself at reset and can be requested again at any time. While `busy` is high, lookups and updates are ignored. Predictions also need the global enable to be set. Branches that the fetch logic marks as mode-changing or as exception-returns never get a prediction.

Top module: `bdt_predictor`

## Requirements
- R1: While reset is held, `busy` is 1 and `pred_valid` is 0. After reset is released, `busy` stays 1 for exactly 2^IDX_W clocks, and every entry is left holding counter value 01.
- R2: The table index is `pc ^ ghr`, where `ghr` is the IDX_W-bit history. Each accepted update shifts `up_taken` into bit 0 of `ghr` and moves the older bits up by one position.
- R3: A lookup accepted at clock edge t sets `pred_valid` to 1 after edge t and holds it for one cycle. `pred_taken` is 1 exactly when the counter read is 2 or 3.
- R4: An accepted update adds 1 to the counter when the branch is taken and subtracts 1 when it is not. The counter saturates at 0 and at 3, and the parity bit is rewritten with it.
- R5: A stored word is {parity, counter[1:0]}, with parity equal to the XOR of the two counter bits. When a word read by a lookup fails this check, the lookup uses counter value 01, so the prediction is not taken. No error is signalled.
- R6: A `flush_req` while idle raises `busy` at the next edge, and `busy` then stays high for 2^IDX_W clocks while every entry is rewritten to 01. While `busy` is high, lookups give no prediction, and updates change neither the table nor `ghr`.
- R7: While `enable` is 0, `pred_valid` stays 0. Updates keep training the table and the history.
- R8: A lookup with `lk_mode_chg` or `lk_exc_ret` set gives `pred_valid` = 0.
- R9: When a lookup and an update land on the same index at the same edge, the update is written, and the lookup reports the value from before the update.
- R10: An update to an entry whose parity fails starts from counter value 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a flush |
| enable | input | 1 | Global prediction enable |
| flush_req | input | 1 | Request to reinitialise the whole table |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_pc | input | IDX_W | Fetch address bits [IDX_W+1:2] for the lookup |
| lk_mode_chg | input | 1 | The looked-up branch changes mode |
| lk_exc_ret | input | 1 | The looked-up branch is an exception return |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | IDX_W | Address bits [IDX_W+1:2] of the resolved branch |
| up_taken | input | 1 | Resolved outcome: 1 means taken |
| pred_valid | output | 1 | A prediction is reported this cycle |
| pred_taken | output | 1 | Predicted direction, qualified by `pred_valid` |
| busy | output | 1 | Flush in progress |

## Verification
The bench first sends a long run of taken updates to one address. This fills the history with ones and drives one counter into saturation. A single update-then-lookup trace cannot show whether the counter saturates or whether the index really XORs in the history; this run separates those cases. Same-cycle lookup/update pairs show whether the read happens before or after the write. Counters are then deposited with bad parity, as a stored 11 and as a stored 00. The only way both cases give the expected result is for the block to substitute 01: that is the one behaviour under which the stored 11 predicts not-taken and the stored 00 trains up to taken after a single update. Finally, a random mix of gated lookups, type flags, updates and mid-stream flushes is compared against the model on every clock.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

  typedef logic [1:0] ctr_t;

  // counter value used after a flush and in place of a word with bad parity
  localparam ctr_t CTR_SAFE = 2'b01;

  // saturating step toward the resolved direction
  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic ctr_taken(ctr_t c);
    return c >= 2'b10;
  endfunction

  function automatic logic [2:0] word_encode(ctr_t c);
    return {^c, c};
  endfunction

  function automatic logic word_bad(logic [2:0] w);
    return ^w;
  endfunction

  function automatic ctr_t word_decode(logic [2:0] w);
    return word_bad(w) ? CTR_SAFE : w[1:0];
  endfunction

endpackage

// File: rtl/bdt_hist.sv
module bdt_hist #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_pc,
  input  logic [IDX_W-1:0] up_pc,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [IDX_W-1:0] up_idx
);

  logic [IDX_W-1:0] ghr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        ghr_q <= '0;
    else if (shift_en) ghr_q <= {ghr_q[IDX_W-2:0], shift_bit};
  end

  assign lk_idx = lk_pc ^ ghr_q;
  assign up_idx = up_pc ^ ghr_q;

  // R2: the newest outcome lands in bit 0
  a_r2_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> ghr_q[0] == $past(shift_bit));

  // R6: history frozen when no update is accepted
  a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(ghr_q));

endmodule

// File: rtl/bdt_flush.sv
module bdt_flush #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_req,
  output logic             busy,
  output logic [IDX_W-1:0] wr_idx
);

  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};
  localparam logic [IDX_W:0]   FULL = {1'b1, {IDX_W{1'b0}}};

  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      if (ptr_q == LAST) busy_q <= 1'b0;
      ptr_q <= ptr_q + 1'b1;
    end else if (flush_req) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end
  end

  assign busy   = busy_q;
  assign wr_idx = ptr_q;

  // independent length counter for the checks below
  logic [IDX_W:0] span_q;
  always_ff @(posedge clk) begin
    if (!rst_n) span_q <= '0;
    else        span_q <= busy_q ? span_q + 1'b1 : '0;
  end

  // R1 / R6: a flush covers every entry exactly once
  a_r6_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> span_q == FULL);

  a_r6_flush_start: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !busy_q) |=> busy_q);

endmodule

// File: rtl/bdt_table.sv
module bdt_table
  import bdt_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fl_we,
  input  logic [IDX_W-1:0] fl_idx,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  output logic             rd_par_err
);

  localparam int DEPTH = 1 << IDX_W;

  logic [2:0] store [DEPTH];
  logic [2:0] rd_word;
  ctr_t       up_old;
  ctr_t       up_new;

  // R10: a corrupted entry is trained from the safe value
  assign up_old = word_decode(store[up_idx]);
  assign up_new = ctr_step(up_old, up_taken);

  always_ff @(posedge clk) begin
    rd_word <= store[rd_idx];              // R9: read sees the pre-write word
    if (fl_we)      store[fl_idx] <= word_encode(CTR_SAFE);
    else if (up_en) store[up_idx] <= word_encode(up_new);
  end

  assign rd_par_err = word_bad(rd_word);
  assign rd_ctr     = word_decode(rd_word);

  // R4: the counter only moves toward the outcome
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_taken) |-> up_new >= up_old);
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !up_taken) |-> up_new <= up_old);

  // R6: the flush walker and the update path never write together
  a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> !up_en);

endmodule

// File: rtl/bdt_predictor.sv
module bdt_predictor
  import bdt_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             flush_req,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_pc,
  input  logic             lk_mode_chg,
  input  logic             lk_exc_ret,
  input  logic             up_valid,
  input  logic [IDX_W-1:0] up_pc,
  input  logic             up_taken,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic             busy
);

  logic [IDX_W-1:0] lk_idx, up_idx, fl_idx;
  logic             up_fire, lk_fire;
  logic             pred_q;
  ctr_t             rd_ctr;
  logic             rd_par_err;

  assign up_fire = up_valid & ~busy;
  assign lk_fire = lk_valid & ~busy & enable & ~lk_mode_chg & ~lk_exc_ret;

  bdt_hist #(.IDX_W(IDX_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_pc(up_pc),
    .shift_en(up_fire), .shift_bit(up_taken),
    .lk_idx(lk_idx), .up_idx(up_idx));

  bdt_flush #(.IDX_W(IDX_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
    .busy(busy), .wr_idx(fl_idx));

  bdt_table #(.IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .fl_we(busy), .fl_idx(fl_idx),
    .up_en(up_fire), .up_idx(up_idx), .up_taken(up_taken),
    .rd_idx(lk_idx), .rd_ctr(rd_ctr), .rd_par_err(rd_par_err));

  always_ff @(posedge clk) begin
    if (!rst_n) pred_q <= 1'b0;
    else        pred_q <= lk_fire;
  end

  assign pred_valid = pred_q;
  assign pred_taken = pred_q & ctr_taken(rd_ctr);

  // R3: accepted lookup answers next cycle
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> pred_valid);
  // R6: nothing predicted from a busy cycle
  a_r6_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !pred_valid);
  // R7: global enable gates predictions
  a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pred_valid);
  // R8: excluded branch kinds get no prediction
  a_r8_type_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_mode_chg || lk_exc_ret) |=> !pred_valid);
  // R5: a bad word never yields a taken guess
  a_r5_parity_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && rd_par_err) |-> !pred_taken);

endmodule

// File: tb/tb_bdt_predictor.sv
module tb_bdt_predictor;

  localparam int IW = 12;
  localparam int N  = 1 << IW;
  localparam int M  = N - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, flush_req = 1'b0;
  logic lk_valid = 1'b0, lk_mode_chg = 1'b0, lk_exc_ret = 1'b0;
  logic [IW-1:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 1'b0, up_taken = 1'b0;
  logic pred_valid, pred_taken, busy;

  always #2 clk = ~clk;  // 250 MHz

  bdt_predictor #(.IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush_req(flush_req),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_mode_chg(lk_mode_chg),
    .lk_exc_ret(lk_exc_ret), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .busy(busy));

  // behavioural model
  int    mdl [N];
  int    ghr = 0;
  bit    mbusy = 1'b1;
  int    mptr = 0;
  int    checks = 0, errors = 0;
  string tag = "R1";

  task automatic cmp(bit ev, bit et, bit eb);
    checks++;
    if (pred_valid !== ev || pred_taken !== et || busy !== eb) begin
      errors++;
      $display("FAIL %s: valid/taken/busy got %0b%0b%0b expected %0b%0b%0b",
               tag, pred_valid, pred_taken, busy, ev, et, eb);
    end
  endtask

  task automatic step(bit lv, int la, bit mc, bit er, bit uv, int ua, bit ut, bit fr);
    bit ev, et;
    int li, ui;
    lk_valid = lv; lk_pc = IW'(la); lk_mode_chg = mc; lk_exc_ret = er;
    up_valid = uv; up_pc = IW'(ua); up_taken = ut; flush_req = fr;
    li = (la ^ ghr) & M;
    ev = lv && !mbusy && enable && !mc && !er;
    et = ev && (mdl[li] >= 2);            // pre-update value
    if (uv && !mbusy) begin
      ui = (ua ^ ghr) & M;
      if (ut) mdl[ui] = (mdl[ui] == 3) ? 3 : mdl[ui] + 1;
      else    mdl[ui] = (mdl[ui] == 0) ? 0 : mdl[ui] - 1;
      ghr = ((ghr << 1) | int'(ut)) & M;
    end
    if (mbusy) begin
      mdl[mptr] = 1;
      if (mptr == M) mbusy = 1'b0;
      mptr = (mptr + 1) & M;
    end else if (fr) begin
      mbusy = 1'b1;
      mptr = 0;
    end
    @(posedge clk);
    @(negedge clk);
    cmp(ev, et, mbusy);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(int a);
    step(1, a, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic train(int a, bit t);
    step(0, 0, 0, 0, 1, a, t, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got run still active expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k, a2;
    for (int i = 0; i < N; i++) mdl[i] = 0;
    // R1: reset state
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp(0, 0, 1);
    rst_n = 1'b1;
    idle(N + 2);           // flush after reset

    // R3: fresh entries read as not taken
    tag = "R3";
    for (int i = 0; i < 8; i++) look(i * 37);

    // R2 / R4: long taken run fills history and saturates one counter
    tag = "R4";
    for (int i = 0; i < 20; i++) train(5, 1);
    tag = "R2";
    look(5); look(5 ^ M); look(0);
    tag = "R4";
    for (int i = 0; i < 3; i++) train(9, 0);
    for (int i = 0; i < 6; i++) look(i);

    // R9: same-index lookup and update at one edge
    tag = "R9";
    k = (7 ^ ghr) & M;
    step(1, 7, 0, 0, 1, 7, 1, 0);
    a2 = k ^ ghr;
    look(a2);

    // R7: disabled lookups give nothing, updates still train
    tag = "R7";
    enable = 1'b0;
    look(3); train(3, 1); train(3, 1); look(3);
    enable = 1'b1;
    look(3); look(a2);

    // R8: excluded branch kinds
    tag = "R8";
    step(1, 5, 1, 0, 0, 0, 0, 0);
    step(1, 5, 0, 1, 0, 0, 0, 0);
    step(1, 5, 1, 1, 0, 0, 0, 0);
    look(5);

    // R5: stored 11 with bad parity reads as 01
    tag = "R5";
    k = (100 ^ ghr) & M;
    dut.u_tab.store[k] = 3'b111;
    mdl[k] = 1;
    look(100);
    look(100);

    // R10: stored 00 with bad parity trains from 01
    tag = "R10";
    k = (200 ^ ghr) & M;
    dut.u_tab.store[k] = 3'b100;
    mdl[k] = 1;
    train(200, 1);
    look(k ^ ghr);

    // R6: flush ignores traffic and restores 01 everywhere
    tag = "R6";
    step(0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 40; i++) step(1, i, 0, 0, 1, i, 1, 0);
    idle(N);
    for (int i = 0; i < 8; i++) look(i);

    // R4: random mix
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      enable = (($urandom % 10) != 0);
      step($urandom % 2, $urandom % 32, ($urandom % 8) == 0, ($urandom % 8) == 0,
           $urandom % 2, $urandom % 32, $urandom % 2, ($urandom % 2500) == 0);
    end
    enable = 1'b1;
    idle(N + 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule